// File: doc/BRIEF.md
# Byte-Serial SPI Master with Queued Transmit

This peripheral drives an SPI bus as master from a small processor's register bus. Software sees three registers: control, status and data. Writing the data register queues one byte. While an earlier byte is still shifting, the new byte waits in a one-entry holding buffer. When the current byte ends, the queued byte takes over on the very next serial clock half-period, so the serial clock runs without a pause between the two bytes.

Receive has only one buffer, a single register. Each finished byte lands there and raises a receive-full flag. The flag stays up until software reads the data register. If a second byte finishes before that read, the older byte is kept and the newer one is lost. An overrun flag records the loss.

Once a queued byte has started, software therefore has one byte time to collect the previous received byte. The serial clock rate is a power-of-four fraction of the bus clock. Clock idle level and sampling phase are set in the control register. Two interrupt lines are driven from the status flags.

Top module: `spi_buffered_master`

## Requirements
- R1: After reset, the control and status registers read 0x00, sclk is low, and both interrupt lines are low.
- R2: Data is shifted out most-significant bit first on mosi. At the same time eight bits are taken from miso, and at the end of the byte they are stored as the received byte, first bit taken in the MSB position.
- R3: The 2-bit rate field is at control bits 4:3. Values 0, 1, 2 and 3 give an sclk period of 2, 8, 32 and 128 bus clocks. A byte written to an idle engine sets receive-full 16*H+1 clock edges after the write edge, where H is half the sclk period.
- R4: If a byte is queued when the current byte ends, the queued byte starts on the same clock edge. Two queued bytes finish 32*H+1 edges after the first write.
- R5: Status bit 2 (transmit-empty) is 1 while the block is enabled and the holding buffer is empty. It drops on the edge that accepts a data write. It rises again on the edge where the held byte moves into the shifter.
- R6: A data write that arrives while the holding buffer is full is discarded.
- R7: A finished byte sets status bit 0 (receive-full). Reading address 2 returns the received byte and clears receive-full.
- R8: If a byte finishes while receive-full is still set, status bit 1 (overrun) is set and the stored received byte keeps its older value.
- R9: Overrun clears only when a strobed read of status (address 1) is followed by a read of data (address 2). A data read alone leaves overrun set.
- R10: Control bit 1 sets the sclk idle level and control bit 2 selects sampling on the trailing edge (1) or the leading edge (0). All four combinations move data correctly, and sclk rests at the idle level between transfers.
- R11: The receive interrupt is (receive-full or overrun) gated by control bit 5. The transmit interrupt is transmit-empty gated by control bit 6.
- R12: While control bit 0 (enable) is 0, the engine stops, sclk idles, the holding buffer and all status flags clear, and data writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on status and data) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq_rx | output | 1 | Receive/overrun interrupt request |
| irq_tx | output | 1 | Transmit-empty interrupt request |

## Verification
Receive-full is due 16*H+1 edges after the write edge for a lone byte. For a queued pair it is due again 32*H+1 edges after the first write. Transmit-empty falls on the write edge and rises one edge later. The bench drives every strobe at a falling edge and samples just after falling edges. It counts falling edges from the write, so the completion times listed above can be compared exactly, and a gap between queued bytes shows up as a late count. Overrun, drop and disable results are read only after the traffic has settled, well past the last due edge.

// File: rtl/spi_buffered_master.sv
module spi_buffered_master #(
  parameter int DW     = 8,
  parameter int RATE_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          irq_rx,
  output logic          irq_tx
);
  localparam int HW = $clog2(2*DW);
  localparam int PW = 2*((1 << RATE_W) - 1) + 1;
  localparam logic [1:0]    A_CTRL = 2'd0;
  localparam logic [1:0]    A_STAT = 2'd1;
  localparam logic [1:0]    A_DATA = 2'd2;
  localparam logic [HW-1:0] LAST   = HW'(2*DW - 1);

  logic [DW-1:0]     ctrl_q;
  logic              en, cpol, cpha, rx_ie, tx_ie;
  logic [RATE_W-1:0] rate;

  assign en    = ctrl_q[0];
  assign cpol  = ctrl_q[1];
  assign cpha  = ctrl_q[2];
  assign rate  = ctrl_q[3 +: RATE_W];
  assign rx_ie = ctrl_q[3 + RATE_W];
  assign tx_ie = ctrl_q[4 + RATE_W];

  logic [DW-1:0] hold, sh, rxsh, rx_data;
  logic          hold_full, busy, rx_full, ovf, ovf_arm, sclk_ph;
  logic [HW-1:0] hidx;
  logic [PW-1:0] pcnt, half_m1;

  assign half_m1 = PW'((32'd1 << (2*rate)) - 32'd1);

  logic tick, lead, done, data_wr, data_rd, stat_rd, load, tx_empty;
  logic [DW-1:0] rx_next;

  assign tick     = busy && (pcnt == '0);
  assign lead     = ~hidx[0];
  assign done     = tick && (hidx == LAST);
  assign data_wr  = en && bus_wr && (bus_addr == A_DATA);
  assign data_rd  = bus_rd && (bus_addr == A_DATA);
  assign stat_rd  = bus_rd && (bus_addr == A_STAT);
  assign load     = hold_full && (!busy || done);
  assign rx_next  = cpha ? {rxsh[DW-2:0], miso} : rxsh;
  assign tx_empty = en && !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      sh        <= '0;
      rxsh      <= '0;
      rx_data   <= '0;
      busy      <= 1'b0;
      rx_full   <= 1'b0;
      ovf       <= 1'b0;
      ovf_arm   <= 1'b0;
      sclk_ph   <= 1'b0;
      hidx      <= '0;
      pcnt      <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata;
      if (!en) begin
        hold_full <= 1'b0;
        sh        <= '0;
        rxsh      <= '0;
        busy      <= 1'b0;
        rx_full   <= 1'b0;
        ovf       <= 1'b0;
        ovf_arm   <= 1'b0;
        sclk_ph   <= 1'b0;
        hidx      <= '0;
        pcnt      <= '0;
      end else begin
        if (data_wr && !hold_full) begin
          hold      <= bus_wdata;
          hold_full <= 1'b1;
        end

        if (tick) begin
          sclk_ph <= ~sclk_ph;
          pcnt    <= half_m1;
          hidx    <= hidx + 1'b1;
          if (lead ^ cpha) rxsh <= {rxsh[DW-2:0], miso};
          if (lead ? (cpha && hidx != '0) : (!cpha && hidx != LAST))
            sh <= {sh[DW-2:0], 1'b0};
          if (done) busy <= 1'b0;
        end else if (busy) begin
          pcnt <= pcnt - 1'b1;
        end

        if (load) begin
          sh        <= hold;
          hold_full <= 1'b0;
          busy      <= 1'b1;
          hidx      <= '0;
          pcnt      <= half_m1;
        end

        if (stat_rd && ovf) ovf_arm <= 1'b1;
        if (data_rd && ovf_arm) begin
          ovf     <= 1'b0;
          ovf_arm <= 1'b0;
        end

        if (done) begin
          if (rx_full && !data_rd) ovf <= 1'b1;
          else begin
            rx_data <= rx_next;
            rx_full <= 1'b1;
          end
        end else if (data_rd) begin
          rx_full <= 1'b0;
        end
      end
    end
  end

  assign sclk   = sclk_ph ^ cpol;
  assign mosi   = sh[DW-1];
  assign irq_rx = rx_ie && (rx_full || ovf);
  assign irq_tx = tx_ie && tx_empty;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {{(DW-4){1'b0}}, busy, tx_empty, ovf, rx_full};
      A_DATA:  bus_rdata = rx_data;
      default: bus_rdata = '0;
    endcase
  end

  AST_TXE_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !hold_full) |=> !tx_empty); // R5

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done && hold_full) |=> (busy && hidx == '0)); // R4

  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol)); // R10

  AST_OVF_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done && rx_full && !data_rd) |=> (ovf && $stable(rx_data))); // R8

  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && data_rd && !done) |=> !rx_full); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !rx_full && !ovf && !hold_full)); // R12
endmodule

// File: tb/spi_buffered_master_tb.sv
`timescale 1ns/1ps
module spi_buffered_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sclk, mosi, miso, irq_rx, irq_tx;

  always #2.5 clk = ~clk;

  spi_buffered_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  int checks = 0;
  int fails  = 0;
  bit done_all = 0;

  logic        tb_cpol = 1'b0, tb_cpha = 1'b0;
  logic [15:0] s_out = '0, s_in = '0;
  int          s_edges = 0;
  logic        mosi_q = 1'b0;

  assign miso = s_out[15];
  always @(negedge clk) mosi_q <= mosi;
  always @(sclk) begin
    if ((sclk != tb_cpol) ^ tb_cpha) begin
      s_in    = {s_in[14:0], mosi_q};
      s_out   = {s_out[14:0], 1'b0};
      s_edges = s_edges + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic prep(input logic [15:0] pattern);
    s_out = pattern; s_in = '0; s_edges = 0;
  endtask

  task automatic wait_rx(inout int n);
    logic [7:0] v;
    peek(2'd1, v);
    while (!v[0] && n < 5000) begin
      @(negedge clk); n++;
      peek(2'd1, v);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(2'd0, v); chk("R1 ctrl", v, 0);
    peek(2'd1, v); chk("R1 status", v, 0);
    chk("R1 sclk", sclk, 0);
    chk("R1 irq", {irq_rx, irq_tx}, 0);
  endtask

  task automatic t_rates();
    logic [7:0] v;
    for (int r = 0; r < 4; r++) begin
      int n;
      tb_cpol = 0; tb_cpha = 0;
      wr(2'd0, 8'h01 | 8'(r << 3));
      repeat (2) @(negedge clk);
      prep({8'hC3 ^ 8'(r), 8'h00});
      wr(2'd2, 8'hA5 ^ 8'(r));
      n = 1;
      wait_rx(n);
      chk("R3 byte time", n, 16 * (1 << (2*r)) + 2);
      chk("R2 mosi msb-first", s_in[7:0], 8'hA5 ^ 8'(r));
      chk("R2 edge count", s_edges, 8);
      rd(2'd2, v);
      chk("R7 read data", v, 8'hC3 ^ 8'(r));
      peek(2'd1, v);
      chk("R7 rx_full cleared", v[0], 0);
    end
  endtask

  task automatic t_queue();
    logic [7:0] v;
    int n;
    wr(2'd0, 8'h09);
    repeat (2) @(negedge clk);
    prep({8'h5A, 8'h3C});
    wr(2'd2, 8'h81); n = 1;
    peek(2'd1, v); chk("R5 txe low after write", v[2], 0);
    @(negedge clk); n++;
    peek(2'd1, v); chk("R5 txe high after move", v[2], 1);
    wr(2'd2, 8'h7E); n += 2;
    peek(2'd1, v); chk("R5 txe low while queued", v[2], 0);
    wait_rx(n);
    chk("R3 first byte time", n, 66);
    rd(2'd2, v); n += 2;
    chk("R4 first rx byte", v, 8'h5A);
    wait_rx(n);
    chk("R4 back-to-back time", n, 130);
    chk("R4 mosi pair", s_in, 16'h817E);
    chk("R4 edge count", s_edges, 16);
    rd(2'd2, v);
    chk("R4 second rx byte", v, 8'h3C);
    peek(2'd1, v); chk("R4 no overrun", v[1], 0);
  endtask

  task automatic t_drop();
    logic [7:0] v;
    wr(2'd0, 8'h01);
    repeat (2) @(negedge clk);
    prep({8'h11, 8'h22});
    wr(2'd2, 8'hB1);
    @(negedge clk);
    wr(2'd2, 8'hB2);
    wr(2'd2, 8'hB3);
    repeat (60) @(negedge clk);
    chk("R6 only two bytes sent", s_edges, 16);
    chk("R6 mosi pair", s_in, 16'hB1B2);
    rd(2'd1, v);
    rd(2'd2, v);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    prep({8'h11, 8'h22});
    wr(2'd2, 8'h44);
    @(negedge clk);
    wr(2'd2, 8'h55);
    repeat (60) @(negedge clk);
    peek(2'd1, v); chk("R8 status full+ovf", v, 8'h07);
    peek(2'd2, v); chk("R8 older byte kept", v, 8'h11);
    rd(2'd2, v);
    peek(2'd1, v); chk("R9 ovf kept after data-only read", v, 8'h06);
    rd(2'd1, v);
    rd(2'd2, v);
    peek(2'd1, v); chk("R9 ovf cleared by sequence", v, 8'h04);
  endtask

  task automatic run_mode(input logic p, input logic h, input logic [7:0] tx, input logic [7:0] sl);
    logic [7:0] v;
    int n;
    tb_cpol = p; tb_cpha = h;
    wr(2'd0, {5'b00001, h, p, 1'b1});
    repeat (3) @(negedge clk);
    chk("R10 idle level", sclk, p);
    prep({sl, 8'h00});
    wr(2'd2, tx); n = 1;
    wait_rx(n);
    chk("R10 mosi", s_in[7:0], tx);
    chk("R10 edge count", s_edges, 8);
    rd(2'd2, v);
    chk("R10 miso byte", v, sl);
    chk("R10 idle after", sclk, p);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    int n;
    tb_cpol = 0; tb_cpha = 0;
    wr(2'd0, 8'h21);
    repeat (2) @(negedge clk);
    chk("R11 irq quiet", {irq_rx, irq_tx}, 0);
    prep({8'h6B, 8'h00});
    wr(2'd2, 8'h19); n = 1;
    wait_rx(n);
    chk("R11 irq_rx on full", irq_rx, 1);
    rd(2'd2, v);
    chk("R11 irq_rx after read", irq_rx, 0);
    wr(2'd0, 8'h61);
    chk("R11 irq_tx enabled", irq_tx, 1);
    wr(2'd2, 8'h0F);
    chk("R11 irq_tx while held", irq_tx, 0);
    n = 1;
    wait_rx(n);
    rd(2'd2, v);
  endtask

  task automatic t_disable();
    logic [7:0] v;
    int n;
    tb_cpol = 0; tb_cpha = 0;
    wr(2'd0, 8'h71);
    repeat (2) @(negedge clk);
    prep({8'h99, 8'h00});
    wr(2'd2, 8'h3A); n = 1;
    wait_rx(n);
    wr(2'd2, 8'h55);
    repeat (20) @(negedge clk);
    wr(2'd0, 8'h70);
    repeat (2) @(negedge clk);
    peek(2'd1, v); chk("R12 flags cleared", v, 0);
    chk("R12 sclk idle", sclk, 0);
    chk("R12 irq low", {irq_rx, irq_tx}, 0);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h71);
    prep(16'h0000);
    repeat (40) @(negedge clk);
    chk("R12 write ignored", s_edges, 0);
    peek(2'd1, v); chk("R12 status after re-enable", v, 8'h04);
    chk("R11 irq_tx after re-enable", irq_tx, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rates();
    t_queue();
    t_drop();
    t_overrun();
    run_mode(1'b1, 1'b1, 8'h4D, 8'h96);
    run_mode(1'b0, 1'b1, 8'hE2, 8'h17);
    run_mode(1'b1, 1'b0, 8'h38, 8'hC5);
    t_irq();
    t_disable();
    done_all = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_all) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule